// File: doc/BRIEF.md
# One-Hot Run-Time Fault Injection Controller

This block lets a set of logic cells that each carry a prebuilt fault be switched between their good and faulty behaviour at run time, with no change to the cells themselves. Each cell computes a 4-input good function held in a 16-entry truth table. A fifth input on the cell, its select bit, swaps that function for a faulty version. The faulty version forces a stuck-at value onto one of the four inputs or onto the cell output. Parameters choose the fault site and the stuck value for each cell.

A circular one-hot token register drives the select bits, so at most one injected fault is live at any moment. Reset places the token on cell 0. Each clock edge with the advance input high moves the token one cell up the ring, and from the last cell it returns to cell 0. A binary index of the token position is output next to the one-hot vector.

A test environment applies a vector set to the cell inputs and records the outputs. It then advances the token and repeats, which grades each prebuilt fault in turn.

Top module: `fault_token_injector`

## Requirements
- R1: While `rst_n` is low, and at once when it falls (asynchronous reset), `sel_onehot` holds only bit 0 set and `sel_index` is 0, whatever `shift_en` does.
- R2: On a rising clock edge with `rst_n` high and `shift_en` high, the set bit of `sel_onehot` moves from position i to position i+1 and `sel_index` goes from i to i+1.
- R3: From position NUM_CELLS-1, an advance moves the token to position 0 and `sel_index` to 0.
- R4: On a rising edge with `shift_en` low, `sel_onehot` and `sel_index` keep their values.
- R5: Out of reset, `sel_onehot` has exactly one bit set at all times.
- R6: `sel_index` is the binary position of the set bit in `sel_onehot`.
- R7: Cell k reads its inputs from `cell_in[4k+3:4k]`, taken as an index n = a + 2b + 4c + 8d, where a is bit 4k. When its select bit is 0, `cell_out[k]` equals bit n of the cell's table, `GOOD_TT[16k+15:16k]`.
- R8: When cell k is selected and its site code `FAULT_SITE[3k+2:3k]` is j in 0..3, `cell_out[k]` equals the table bit addressed by the inputs with input j replaced by `FAULT_VAL[k]`.
- R9: When cell k is selected and its site code is 4 (output site), `cell_out[k]` equals `FAULT_VAL[k]` for every input pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Token register clock |
| rst_n | input | 1 | Asynchronous active-low reset; puts the token on cell 0 |
| shift_en | input | 1 | Advance the token one cell on this clock edge |
| cell_in | input | 4*NUM_CELLS | Four data inputs per cell; cell k uses bits 4k+3..4k |
| cell_out | output | NUM_CELLS | One output per cell, good or faulty as selected |
| sel_onehot | output | NUM_CELLS | One-hot fault select vector driving the cells |
| sel_index | output | $clog2(NUM_CELLS) | Binary position of the active fault |

## Verification
The hardest case to reach from the ports is the injected behaviour of one particular cell under every input pattern. That requires the token to be parked on that cell and held while all sixteen patterns are applied. The stimulus therefore walks the token across the ring one cell at a time and sweeps the full input space at every stop. It advances only on the last pattern, so the wrap from the top cell back to cell 0 falls inside the sweep. A second reset is also asserted in mid-rotation with the advance input held high, which shows that the asynchronous reset overrides a pending advance.

// File: rtl/fti_pkg.sv
package fti_pkg;
   localparam int CELL_IN_W = 4;
   localparam int TT_W      = 1 << CELL_IN_W;
   localparam int SITE_W    = 3;

   typedef logic [SITE_W-1:0] site_t;

   // Site codes 0..3 name a cell input; this code names the cell output.
   localparam site_t SITE_OUTPUT = site_t'(4);

   function automatic bit site_legal(input site_t s);
      return s <= SITE_OUTPUT;
   endfunction
endpackage

// File: rtl/fti_token_ring.sv
module fti_token_ring #(
   parameter int RING_LEN = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                advance,
   output logic [RING_LEN-1:0] token
);
   localparam logic [RING_LEN-1:0] HOME = {{(RING_LEN-1){1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         token <= HOME;
      end else if (advance) begin
         token <= {token[RING_LEN-2:0], token[RING_LEN-1]};
      end
   end
endmodule

// File: rtl/fti_onehot_index.sv
module fti_onehot_index #(
   parameter int VEC_W = 5,
   parameter int IDX_W = 3
) (
   input  logic [VEC_W-1:0] onehot,
   output logic [IDX_W-1:0] index
);
   always_comb begin
      index = '0;
      for (int i = 0; i < VEC_W; i++) begin
         if (onehot[i]) begin
            index = index | IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/fti_fault_cell.sv
module fti_fault_cell
   import fti_pkg::*;
#(
   parameter logic [TT_W-1:0] TT    = '0,
   parameter site_t           SITE  = SITE_OUTPUT,
   parameter logic            STUCK = 1'b0
) (
   input  logic [CELL_IN_W-1:0] in_bits,
   input  logic                 inject,
   output logic                 out_bit
);
   if (!site_legal(SITE)) begin : g_bad_site
      $error("fti_fault_cell: site code out of range");
   end

   if (SITE == SITE_OUTPUT) begin : g_out_site
      logic good_bit;
      always_comb begin
         good_bit = TT[in_bits];
         out_bit  = inject ? STUCK : good_bit;
      end
   end else begin : g_in_site
      localparam int PIN = int'(SITE);
      logic [CELL_IN_W-1:0] eff_bits;
      always_comb begin
         eff_bits      = in_bits;
         eff_bits[PIN] = inject ? STUCK : in_bits[PIN];
         out_bit       = TT[eff_bits];
      end
   end
endmodule

// File: rtl/fault_token_injector.sv
module fault_token_injector
   import fti_pkg::*;
#(
   parameter int                        NUM_CELLS  = 5,
   parameter logic [NUM_CELLS*TT_W-1:0]   GOOD_TT    =
      {16'hCAFE, 16'h1234, 16'h6996, 16'hFFFE, 16'h8000},
   parameter logic [NUM_CELLS*SITE_W-1:0] FAULT_SITE =
      {3'd4, 3'd2, 3'd0, 3'd4, 3'd1},
   parameter logic [NUM_CELLS-1:0]        FAULT_VAL  = 5'b01100
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           shift_en,
   input  logic [NUM_CELLS*CELL_IN_W-1:0] cell_in,
   output logic [NUM_CELLS-1:0]           cell_out,
   output logic [NUM_CELLS-1:0]           sel_onehot,
   output logic [$clog2(NUM_CELLS)-1:0]   sel_index
);
   localparam int IDX_W = $clog2(NUM_CELLS);

   if (NUM_CELLS < 2) begin : g_bad_count
      $error("fault_token_injector: NUM_CELLS must be at least 2");
   end

   fti_token_ring #(.RING_LEN(NUM_CELLS)) u_ring (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (shift_en),
      .token   (sel_onehot)
   );

   fti_onehot_index #(.VEC_W(NUM_CELLS), .IDX_W(IDX_W)) u_index (
      .onehot (sel_onehot),
      .index  (sel_index)
   );

   for (genvar k = 0; k < NUM_CELLS; k++) begin : g_cell
      fti_fault_cell #(
         .TT    (GOOD_TT[k*TT_W +: TT_W]),
         .SITE  (site_t'(FAULT_SITE[k*SITE_W +: SITE_W])),
         .STUCK (FAULT_VAL[k])
      ) u_cell (
         .in_bits (cell_in[k*CELL_IN_W +: CELL_IN_W]),
         .inject  (sel_onehot[k]),
         .out_bit (cell_out[k])
      );
   end
endmodule

// File: rtl/fti_checker.sv
module fti_checker #(
   parameter int                      NUM_CELLS  = 5,
   parameter int                      IDX_W      = 3,
   parameter logic [NUM_CELLS*3-1:0]  FAULT_SITE = '0,
   parameter logic [NUM_CELLS-1:0]    FAULT_VAL  = '0
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 shift_en,
   input logic [NUM_CELLS-1:0] sel_onehot,
   input logic [NUM_CELLS-1:0] cell_out,
   input logic [IDX_W-1:0]     sel_index
);
   localparam logic [IDX_W-1:0]     LAST = IDX_W'(NUM_CELLS - 1);
   localparam logic [NUM_CELLS-1:0] ONE  = {{(NUM_CELLS-1){1'b0}}, 1'b1};

   AST_RESET_HOME: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (sel_index == '0 && sel_onehot == ONE)); // R1

   AST_ADVANCE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && sel_index != LAST) |=> (sel_index == $past(sel_index) + IDX_W'(1))); // R2

   AST_ADVANCE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && sel_index == LAST) |=> (sel_index == '0)); // R3

   AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(sel_onehot)); // R4

   AST_SINGLE_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(sel_onehot) == 1); // R5

   AST_INDEX_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_onehot >> sel_index) == ONE); // R6

   for (genvar k = 0; k < NUM_CELLS; k++) begin : g_out_chk
      if (FAULT_SITE[k*3 +: 3] == 3'd4) begin : g_site
         AST_OUT_STUCK: assert property (@(posedge clk) disable iff (!rst_n)
            sel_onehot[k] |-> (cell_out[k] == FAULT_VAL[k])); // R9
      end
   end
endmodule

bind fault_token_injector fti_checker #(
   .NUM_CELLS  (NUM_CELLS),
   .IDX_W      (IDX_W),
   .FAULT_SITE (FAULT_SITE),
   .FAULT_VAL  (FAULT_VAL)
) u_fti_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .shift_en   (shift_en),
   .sel_onehot (sel_onehot),
   .cell_out   (cell_out),
   .sel_index  (sel_index)
);

// File: tb/fault_token_injector_tb.sv
`timescale 1ns/1ps
module fault_token_injector_tb_top;
   localparam int N  = 5;
   localparam int IW = $clog2(N);
   localparam int DW = N * 4;
   localparam logic [N*16-1:0] TT   = {16'hCAFE, 16'h1234, 16'h6996, 16'hFFFE, 16'h8000};
   localparam logic [N*3-1:0]  SITE = {3'd4, 3'd2, 3'd0, 3'd4, 3'd1};
   localparam logic [N-1:0]    VAL  = 5'b01100;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          shift_en = 1'b0;
   logic [DW-1:0] cell_in = '0;
   logic [N-1:0]  cell_out;
   logic [N-1:0]  sel_onehot;
   logic [IW-1:0] sel_index;

   int    checks = 0;
   int    errors = 0;
   int    pos = 0;
   string state_tag = "R1 reset";
   bit    done = 0;

   always #2 clk = ~clk;

   fault_token_injector #(
      .NUM_CELLS(N), .GOOD_TT(TT), .FAULT_SITE(SITE), .FAULT_VAL(VAL)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .cell_in(cell_in),
      .cell_out(cell_out), .sel_onehot(sel_onehot), .sel_index(sel_index)
   );

   function automatic logic model_cell(int k, logic [3:0] din, bit chosen);
      logic [15:0] table_k = TT[k*16 +: 16];
      int          site    = int'(SITE[k*3 +: 3]);
      logic [3:0]  d       = din;
      if (chosen && site < 4) d[site] = VAL[k];
      if (chosen && site == 4) return VAL[k];
      return table_k[d];
   endfunction

   task automatic check_state();
      int ones = 0;
      for (int i = 0; i < N; i++) if (sel_onehot[i]) ones++;
      checks++;
      if (ones != 1) begin
         errors++;
         $display("FAIL R5 token count: got %0d ones expected 1", ones);
      end
      checks++;
      if (sel_onehot != N'(1 << pos)) begin
         errors++;
         $display("FAIL %s select vector: got %b expected %b", state_tag, sel_onehot, N'(1 << pos));
      end
      checks++;
      if (int'(sel_index) != pos) begin
         errors++;
         $display("FAIL R6 index: got %0d expected %0d", sel_index, pos);
      end
   endtask

   task automatic check_cells();
      for (int k = 0; k < N; k++) begin
         bit    chosen = (k == pos);
         logic  exp    = model_cell(k, cell_in[k*4 +: 4], chosen);
         string tag    = !chosen ? "R7 good" : (SITE[k*3 +: 3] == 3'd4 ? "R9 output stuck" : "R8 input stuck");
         checks++;
         if (cell_out[k] !== exp) begin
            errors++;
            $display("FAIL %s cell %0d in=%h: got %b expected %b", tag, k, cell_in[k*4 +: 4], cell_out[k], exp);
         end
      end
   endtask

   task automatic step(input logic sh, input logic [DW-1:0] din);
      @(negedge clk);
      shift_en = sh;
      cell_in  = din;
      #1;
      check_state();
      check_cells();
      @(posedge clk);
      if (sh) begin
         state_tag = (pos == N-1) ? "R3 wrap" : "R2 advance";
         pos = (pos + 1) % N;
      end else begin
         state_tag = "R4 hold";
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      shift_en = 1'b1;
      #1;
      check_state();                       // R1 during reset with advance high
      @(negedge clk);
      rst_n = 1'b1;
      shift_en = 1'b0;
      for (int i = 0; i < 4; i++) step(1'b0, DW'($urandom));
      for (int i = 0; i < 2*N; i++) step(1'b1, DW'($urandom));
      for (int c = 0; c < N; c++) begin
         for (int p = 0; p < 16; p++) step(p == 15, {N{4'(p)}});
      end
      step(1'b1, DW'($urandom));
      step(1'b1, DW'($urandom));
      @(negedge clk);
      shift_en = 1'b1;
      rst_n = 1'b0;
      pos = 0;
      state_tag = "R1 mid-run reset";
      #1;
      check_state();
      repeat (2) @(negedge clk);
      #1;
      check_state();
      @(negedge clk);
      rst_n = 1'b1;
      shift_en = 1'b0;
      for (int i = 0; i < 200; i++) step(1'($urandom), DW'($urandom));
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule